// File: doc/BRIEF.md
# Shared-Scalar SIMD Visibility Correlator

This block integrates cross-correlation products (visibilities) for one frequency channel of a radio interferometer. It is a row of `LANES` identical lanes that step in lock step under one controller. At each time step the input stream delivers two lines of dual-polarization complex station samples in a single transfer. The first line holds one station per lane and is latched in the lanes. The second holds `ENTRIES` stations and is written as a vector into a small shared scalar buffer. The controller then reads the buffer one entry per cycle and broadcasts that entry to every lane. Each lane multiplies its own sample by the complex conjugate of the broadcast sample for all four polarization pairings, and adds the results into its accumulator bank at the slot for that entry.

After `DUMP_LEN` time steps the dump is complete. The controller streams out every accumulated visibility and holds off the input until the last word has left. The first time step of the next dump overwrites the accumulators, so no dump carries sums over from the previous one. Arithmetic is fixed point: each component of an input is a signed 32-bit value, and each component of an accumulator is a signed 64-bit value that saturates.

The controller has three states. `ST_ACCEPT` waits for a line transfer. `ST_BCAST` walks the buffer entries. `ST_DRAIN` emits the readout. Its transitions are:
- take: `ST_ACCEPT`→`ST_BCAST` when a transfer completes.
- next_step: `ST_BCAST`→`ST_ACCEPT` after the last entry of a step that is not the final step.
- dump_done: `ST_BCAST`→`ST_DRAIN` after the last entry of the final step.
- drained: `ST_DRAIN`→`ST_ACCEPT` after the last readout index.

Top module: `corr_simd_array`

## Requirements
- R1: After reset, `in_ready` is 1 and `busy` and `out_valid` are 0.
- R2: A station sample is 128 bits: X real [31:0], X imaginary [63:32], Y real [95:64], Y imaginary [127:96]. Lane k takes bits [k*128 +: 128] of `in_lane_line`, and entry e takes bits [e*128 +: 128] of `in_bcast_line`. For a lane value a+jb and a broadcast value c+jd, one step adds ac+bd to the real part and bc−ad to the imaginary part.
- R3: Each lane/entry pair yields four visibilities, coded 0=XX, 1=XY, 2=YX, 3=YY. The first letter is the polarization of the lane station and the second is the polarization of the conjugated broadcast station.
- R4: A visibility is the sum over the `DUMP_LEN` accepted steps of one dump. Values from earlier dumps do not contribute.
- R5: A readout is exactly `ENTRIES*LANES*4` words in this order: entry index (outermost), then lane index, then polarization code. `out_last` is high on the final word only.
- R6: `busy` is high for every readout word, and `in_ready` is 0 whenever `busy` is 1.
- R7: Each accumulator component saturates at 2^63−1 and at −2^63 instead of wrapping.
- R8: After a transfer, `in_ready` stays 0 for exactly `ENTRIES` cycles before the next step can be taken (the final step of a dump goes on to the readout instead).
- R9: A line presented with `in_valid` high while `in_ready` is 0 is ignored and changes no visibility.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The input lines are valid |
| in_ready | output | 1 | The block takes a line this cycle if `in_valid` is high |
| in_lane_line | input | LANES*128 | One station sample per lane |
| in_bcast_line | input | ENTRIES*128 | Station samples for the shared buffer |
| busy | output | 1 | A readout is in progress |
| out_valid | output | 1 | A visibility word is present |
| out_last | output | 1 | Final word of the readout |
| out_re | output | 64 | Visibility, real part |
| out_im | output | 64 | Visibility, imaginary part |

## Verification
The bench builds the block with three lanes, two shared entries and a four-step dump. The lane count is not a power of two, which exercises the wrap logic of the readout indices. The short dump lets five full dumps run back to back: two with small random values, one with full-scale random values, and two with extreme values that drive the accumulators into positive and then negative saturation. Between dumps the bench presents junk lines while the block is busy. Every dump's 24 readout words are compared against a model of all station pairs held in the bench.

// File: rtl/corr_pkg.sv
`timescale 1ns/1ps
package corr_pkg;
    localparam int CMP_W = 32;
    localparam int SMP_W = 4 * CMP_W;
    localparam int ACC_W = 64;
    localparam int XW    = ACC_W + 2;
    localparam int NPOL  = 4;

    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    // Dual-polarization complex sample; x_re occupies the least significant bits.
    typedef struct packed {
        logic signed [CMP_W-1:0] y_im;
        logic signed [CMP_W-1:0] y_re;
        logic signed [CMP_W-1:0] x_im;
        logic signed [CMP_W-1:0] x_re;
    } stn_t;

    typedef struct packed {
        logic signed [ACC_W-1:0] im;
        logic signed [ACC_W-1:0] re;
    } vis_t;

    typedef enum logic [1:0] {ST_ACCEPT, ST_BCAST, ST_DRAIN} ctrl_st_e;

    // Add an increment to an accumulator component, clamping at the signed bounds.
    function automatic logic signed [ACC_W-1:0] sat_add(
        input logic signed [ACC_W-1:0] base,
        input logic signed [XW-1:0]    inc
    );
        logic signed [XW-1:0] s;
        s = XW'(base) + inc;
        if (s > XW'(ACC_MAX))      return ACC_MAX;
        else if (s < XW'(ACC_MIN)) return ACC_MIN;
        else                       return s[ACC_W-1:0];
    endfunction
endpackage

// File: rtl/corr_ctrl.sv
`timescale 1ns/1ps
module corr_ctrl
    import corr_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int ENTRIES  = 4,
    parameter int DUMP_LEN = 1200,
    parameter int EW       = 2,
    parameter int LW       = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          out_pending,
    output logic          in_ready,
    output logic          busy,
    output logic          load,
    output logic          mac_en,
    output logic          clear,
    output logic [EW-1:0] entry,
    output logic          rd_en,
    output logic [EW-1:0] rd_entry,
    output logic [LW-1:0] rd_lane,
    output logic [1:0]    rd_pol,
    output logic          rd_last
);
    localparam int SW = (DUMP_LEN > 1) ? $clog2(DUMP_LEN) : 1;

    ctrl_st_e      st_q, st_d;
    logic [EW-1:0] ent_q;
    logic [SW-1:0] step_q;
    logic [EW-1:0] re_q;
    logic [LW-1:0] rl_q;
    logic [1:0]    rp_q;
    logic          ent_last, step_last, rd_end;

    assign ent_last  = (ent_q == EW'(ENTRIES - 1));
    assign step_last = (step_q == SW'(DUMP_LEN - 1));
    assign rd_end    = (re_q == EW'(ENTRIES - 1)) && (rl_q == LW'(LANES - 1)) && (rp_q == 2'd3);

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_ACCEPT: if (load)     st_d = ST_BCAST;
            ST_BCAST:  if (ent_last) st_d = step_last ? ST_DRAIN : ST_ACCEPT;
            ST_DRAIN:  if (rd_end)   st_d = ST_ACCEPT;
            default:                 st_d = ST_ACCEPT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_ACCEPT;
        else        st_q <= st_d;
    end

    // Outputs
    always_comb begin
        in_ready = 1'b0;
        busy     = out_pending;
        load     = 1'b0;
        mac_en   = 1'b0;
        clear    = 1'b0;
        rd_en    = 1'b0;
        unique case (st_q)
            ST_ACCEPT: begin
                in_ready = ~out_pending;
                load     = in_valid & ~out_pending;
            end
            ST_BCAST: begin
                mac_en = 1'b1;
                clear  = (step_q == '0);
            end
            ST_DRAIN: begin
                busy  = 1'b1;
                rd_en = 1'b1;
            end
            default: ;
        endcase
    end

    assign entry    = ent_q;
    assign rd_entry = re_q;
    assign rd_lane  = rl_q;
    assign rd_pol   = rp_q;
    assign rd_last  = rd_end;

    // Schedule counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_q  <= '0;
            step_q <= '0;
            re_q   <= '0;
            rl_q   <= '0;
            rp_q   <= '0;
        end else begin
            if (st_q == ST_BCAST) begin
                ent_q <= ent_last ? '0 : ent_q + EW'(1);
                if (ent_last) step_q <= step_last ? '0 : step_q + SW'(1);
            end
            if (st_q == ST_DRAIN) begin
                if (rd_end) begin
                    re_q <= '0;
                    rl_q <= '0;
                    rp_q <= '0;
                end else if (rp_q != 2'd3) begin
                    rp_q <= rp_q + 2'd1;
                end else begin
                    rp_q <= '0;
                    if (rl_q == LW'(LANES - 1)) begin
                        rl_q <= '0;
                        re_q <= re_q + EW'(1);
                    end else begin
                        rl_q <= rl_q + LW'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/corr_lane.sv
`timescale 1ns/1ps
module corr_lane
    import corr_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int EW      = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mac_en,
    input  logic          clear,
    input  logic [EW-1:0] entry,
    input  stn_t          lane_smp,
    input  stn_t          bc_smp,
    input  logic [EW-1:0] rd_entry,
    input  logic [1:0]    rd_pol,
    output vis_t          rd_vis
);
    vis_t pol_rd [NPOL];

    for (genvar p = 0; p < NPOL; p++) begin : g_pol
        logic signed [CMP_W-1:0]   a, b, c, d;
        logic signed [2*CMP_W-1:0] ac, bd, bc, ad;
        logic signed [XW-1:0]      inc_re, inc_im;
        vis_t                      acc_q [ENTRIES];

        // Codes 2 and 3 use the lane's Y polarization; odd codes use the broadcast Y.
        assign a = (p >= 2) ? lane_smp.y_re : lane_smp.x_re;
        assign b = (p >= 2) ? lane_smp.y_im : lane_smp.x_im;
        assign c = (p % 2 == 1) ? bc_smp.y_re : bc_smp.x_re;
        assign d = (p % 2 == 1) ? bc_smp.y_im : bc_smp.x_im;

        assign ac = a * c;
        assign bd = b * d;
        assign bc = b * c;
        assign ad = a * d;

        assign inc_re = XW'(ac) + XW'(bd);
        assign inc_im = XW'(bc) - XW'(ad);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < ENTRIES; i++) acc_q[i] <= '0;
            end else if (mac_en) begin
                acc_q[entry].re <= sat_add(clear ? '0 : acc_q[entry].re, inc_re);
                acc_q[entry].im <= sat_add(clear ? '0 : acc_q[entry].im, inc_im);
            end
        end

        assign pol_rd[p] = acc_q[rd_entry];
    end

    assign rd_vis = pol_rd[rd_pol];
endmodule

// File: rtl/corr_simd_array.sv
`timescale 1ns/1ps
module corr_simd_array
    import corr_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int ENTRIES  = 4,
    parameter int DUMP_LEN = 1200
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [LANES*SMP_W-1:0]   in_lane_line,
    input  logic [ENTRIES*SMP_W-1:0] in_bcast_line,
    output logic                     busy,
    output logic                     out_valid,
    output logic                     out_last,
    output logic signed [ACC_W-1:0]  out_re,
    output logic signed [ACC_W-1:0]  out_im
);
    localparam int EW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

    logic          load, mac_en, clear, rd_en, rd_last;
    logic [EW-1:0] entry, rd_entry;
    logic [LW-1:0] rd_lane;
    logic [1:0]    rd_pol;
    logic          out_valid_q, out_last_q;

    stn_t ssrf_q [ENTRIES];
    stn_t lane_q [LANES];
    stn_t bc_cur;
    vis_t lane_rd [LANES];
    vis_t sel;

    corr_ctrl #(
        .LANES(LANES), .ENTRIES(ENTRIES), .DUMP_LEN(DUMP_LEN), .EW(EW), .LW(LW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_pending(out_valid_q),
        .in_ready(in_ready), .busy(busy), .load(load), .mac_en(mac_en), .clear(clear),
        .entry(entry), .rd_en(rd_en), .rd_entry(rd_entry), .rd_lane(rd_lane),
        .rd_pol(rd_pol), .rd_last(rd_last)
    );

    // Line capture: the broadcast line is written into the shared buffer as a vector.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) ssrf_q[e] <= '0;
            for (int l = 0; l < LANES; l++)   lane_q[l] <= '0;
        end else if (load) begin
            for (int e = 0; e < ENTRIES; e++) ssrf_q[e] <= in_bcast_line[e*SMP_W +: SMP_W];
            for (int l = 0; l < LANES; l++)   lane_q[l] <= in_lane_line[l*SMP_W +: SMP_W];
        end
    end

    assign bc_cur = ssrf_q[entry];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        corr_lane #(.ENTRIES(ENTRIES), .EW(EW)) u_lane (
            .clk(clk), .rst_n(rst_n), .mac_en(mac_en), .clear(clear), .entry(entry),
            .lane_smp(lane_q[l]), .bc_smp(bc_cur), .rd_entry(rd_entry), .rd_pol(rd_pol),
            .rd_vis(lane_rd[l])
        );
    end

    assign sel = lane_rd[rd_lane];

    // Registered readout stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
            out_last_q  <= 1'b0;
            out_re      <= '0;
            out_im      <= '0;
        end else begin
            out_valid_q <= rd_en;
            out_last_q  <= rd_en & rd_last;
            if (rd_en) begin
                out_re <= sel.re;
                out_im <= sel.im;
            end
        end
    end

    assign out_valid = out_valid_q;
    assign out_last  = out_last_q;
endmodule

// File: rtl/corr_chk.sv
`timescale 1ns/1ps
module corr_chk #(
    parameter int LANES   = 4,
    parameter int ENTRIES = 4
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic busy,
    input logic out_valid,
    input logic out_last
);
    localparam int TOTAL = ENTRIES * LANES * 4;
    localparam int CW    = $clog2(TOTAL + 1);

    logic [CW-1:0] wcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         wcnt <= '0;
        else if (out_valid) wcnt <= out_last ? '0 : wcnt + CW'(1);
    end

    // R6
    busy_gates_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready);

    // R6
    word_in_readout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

    // R5
    last_is_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R5
    last_at_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_last == (wcnt == CW'(TOTAL - 1))));

    // R5
    quiet_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> !out_valid);

    // R8
    accept_holds_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
endmodule

bind corr_simd_array corr_chk #(.LANES(LANES), .ENTRIES(ENTRIES)) u_corr_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .busy(busy), .out_valid(out_valid), .out_last(out_last)
);

// File: tb/tb_corr_simd_array.sv
`timescale 1ns/1ps
module tb_corr_simd_array;
    import corr_pkg::*;

    localparam int LANES    = 3;
    localparam int ENTRIES  = 2;
    localparam int DUMP_LEN = 4;
    localparam int CLK_NS   = 20;

    typedef struct {
        logic signed [ACC_W-1:0] re;
        logic signed [ACC_W-1:0] im;
        logic                    last;
        string                   tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid;
    logic in_ready;
    logic [LANES*SMP_W-1:0]   in_lane_line;
    logic [ENTRIES*SMP_W-1:0] in_bcast_line;
    logic busy, out_valid, out_last;
    logic signed [ACC_W-1:0] out_re, out_im;

    int tests  = 0;
    int failed = 0;
    exp_t q[$];
    logic [31:0] seed = 32'h1234_5678;
    stn_t ls [DUMP_LEN][LANES];
    stn_t bs [DUMP_LEN][ENTRIES];

    always #(CLK_NS/2) clk = ~clk;

    corr_simd_array #(.LANES(LANES), .ENTRIES(ENTRIES), .DUMP_LEN(DUMP_LEN)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_lane_line(in_lane_line), .in_bcast_line(in_bcast_line), .busy(busy),
        .out_valid(out_valid), .out_last(out_last), .out_re(out_re), .out_im(out_im)
    );

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    function automatic logic signed [31:0] val(input int mode, input bit lane_side);
        logic signed [31:0] r;
        r = rnd();
        case (mode)
            0:       return r >>> 16;
            1:       return 32'sh8000_0000;
            2:       return lane_side ? 32'sh8000_0000 : 32'sh7FFF_FFFF;
            default: return r;
        endcase
    endfunction

    function automatic logic signed [ACC_W-1:0] clamp(input logic signed [XW-1:0] s);
        logic signed [XW-1:0] hi;
        hi = XW'(64'sh7FFF_FFFF_FFFF_FFFF);
        if (s > hi)          return 64'sh7FFF_FFFF_FFFF_FFFF;
        else if (s < -hi - 1) return 64'sh8000_0000_0000_0000;
        else                  return s[ACC_W-1:0];
    endfunction

    task automatic make_dump(input int mode);
        for (int t = 0; t < DUMP_LEN; t++) begin
            for (int l = 0; l < LANES; l++)
                ls[t][l] = '{y_im: val(mode, 1), y_re: val(mode, 1), x_im: val(mode, 1), x_re: val(mode, 1)};
            for (int e = 0; e < ENTRIES; e++)
                bs[t][e] = '{y_im: val(mode, 0), y_re: val(mode, 0), x_im: val(mode, 0), x_re: val(mode, 0)};
        end
    endtask

    // R2 R3 R4 R5 R7: reference of all station pairs, pushed in readout order.
    task automatic push_expected(input string tag);
        for (int e = 0; e < ENTRIES; e++)
            for (int l = 0; l < LANES; l++)
                for (int p = 0; p < 4; p++) begin
                    exp_t it;
                    logic signed [ACC_W-1:0] are, aim;
                    are = '0;
                    aim = '0;
                    for (int t = 0; t < DUMP_LEN; t++) begin
                        logic signed [31:0] a, b, c, d;
                        logic signed [XW-1:0] ire, iim;
                        a = (p >= 2) ? ls[t][l].y_re : ls[t][l].x_re;
                        b = (p >= 2) ? ls[t][l].y_im : ls[t][l].x_im;
                        c = (p % 2) ? bs[t][e].y_re : bs[t][e].x_re;
                        d = (p % 2) ? bs[t][e].y_im : bs[t][e].x_im;
                        ire = XW'(a) * XW'(c) + XW'(b) * XW'(d);
                        iim = XW'(b) * XW'(c) - XW'(a) * XW'(d);
                        are = clamp(XW'(are) + ire);
                        aim = clamp(XW'(aim) + iim);
                    end
                    it.re   = are;
                    it.im   = aim;
                    it.last = (e == ENTRIES - 1) && (l == LANES - 1) && (p == 3);
                    it.tag  = tag;
                    q.push_back(it);
                end
    endtask

    task automatic run_dump(input int mode, input string tag);
        make_dump(mode);
        push_expected(tag);
        for (int t = 0; t < DUMP_LEN; t++) begin
            int lo;
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            for (int l = 0; l < LANES; l++)   in_lane_line[l*SMP_W +: SMP_W]  = ls[t][l];
            for (int e = 0; e < ENTRIES; e++) in_bcast_line[e*SMP_W +: SMP_W] = bs[t][e];
            in_valid = 1'b1;
            @(posedge clk);
            #1 in_valid = 1'b0;
            if (t != DUMP_LEN - 1) begin
                // R8: in_ready low for ENTRIES cycles after each transfer
                lo = 0;
                @(negedge clk);
                while (!in_ready && lo < 100) begin
                    lo++;
                    @(negedge clk);
                end
                tests++;
                if (lo != ENTRIES) begin
                    failed++;
                    $display("FAIL R8 hold-off cycles actual=%0d expected=%0d", lo, ENTRIES);
                end
            end
        end
        // R9: junk presented while busy must be ignored
        @(negedge clk);
        while (!busy) @(negedge clk);
        while (busy) begin
            in_lane_line  = {LANES{rnd(), rnd(), rnd(), rnd()}};
            in_bcast_line = {ENTRIES{rnd(), rnd(), rnd(), rnd()}};
            in_valid      = 1'b1;
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    // Monitor: scoreboard comparison of each readout word
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (busy && in_ready) begin
                tests++;
                failed++;
                $display("FAIL R6 in_ready actual=1 expected=0 while busy");
            end
            if (out_valid) begin
                tests++;
                if (!busy) begin
                    failed++;
                    $display("FAIL R6 busy actual=0 expected=1 during readout");
                end
                if (q.size() == 0) begin
                    tests++;
                    failed++;
                    $display("FAIL R5 extra word actual=%0d expected none", out_re);
                end else begin
                    exp_t it;
                    it = q.pop_front();
                    tests++;
                    if (out_re !== it.re || out_im !== it.im) begin
                        failed++;
                        $display("FAIL %s visibility actual=(%0d,%0d) expected=(%0d,%0d)",
                                 it.tag, out_re, out_im, it.re, it.im);
                    end
                    tests++;
                    if (out_last !== it.last) begin
                        failed++;
                        $display("FAIL R5 out_last actual=%0b expected=%0b", out_last, it.last);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_NS * 200000);
        tests++;
        failed++;
        $display("FAIL watchdog expired, %0d words pending", q.size());
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        rst_n         = 1'b0;
        in_valid      = 1'b0;
        in_lane_line  = '0;
        in_bcast_line = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        tests++;
        if (in_ready !== 1'b1 || busy !== 1'b0 || out_valid !== 1'b0) begin
            failed++;
            $display("FAIL R1 reset state actual=%b%b%b expected=100", in_ready, busy, out_valid);
        end
        run_dump(0, "R2 R3 R5");
        run_dump(0, "R4 R9");
        run_dump(1, "R7 positive");
        run_dump(2, "R7 negative");
        run_dump(3, "R2 R3 full-scale");
        repeat (5) @(negedge clk);
        tests++;
        if (q.size() != 0) begin
            failed++;
            $display("FAIL R5 words missing actual=%0d expected=0", q.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule